// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

This block is a fully synchronous, digital tri-state phase-frequency comparator. A fast sampling clock watches two single-bit inputs, a reference signal and a feedback signal from a divided oscillator. Each input passes through a two-flop synchronizer, and its rising edges are detected. A reference edge raises an "up" request and a feedback edge raises a "down" request. Once both requests are up, they stay up together for a programmable overlap interval and then clear in the same cycle.

The block produces three kinds of output:
- The two requests.
- A two-bit drive code for an external charge pump: source, sink, high-impedance, or both during the overlap.
- An error pulse that is high whenever either request is high.

When the loop is locked the error pulse shrinks to the overlap interval. A counting qualifier uses this to raise a lock flag after enough consecutive narrow pulses. Any wide pulse drops the flag.

Top module: `pfd_lock_top`

## Requirements
- R1: Each rising edge of `ref_i` (after two synchronizer stages) sets the up request. While up is set and down is clear, `drive_o` is 2'b10 (source). With no edges on either input, both requests stay clear.
- R2: Each synchronized rising edge of `fb_i` sets the down request. While down is set and up is clear, `drive_o` is 2'b01 (sink).
- R3: Once both requests are set, they stay set together for exactly OVERLAP_CYCLES sampling cycles, with `drive_o` = 2'b11. They then clear in the same cycle and `drive_o` returns to 2'b00 (high-impedance).
- R4: There is no dead zone. Edges in the same cycle give an error pulse exactly OVERLAP_CYCLES wide. A lead of d cycles by one input gives a pulse d+OVERLAP_CYCLES wide.
- R5: When the reference runs faster than the feedback, the source code is present for more cycles than the sink code.
- R6: When the reference runs slower than the feedback, the sink code is present for more cycles than the source code.
- R7: With no reference edges, a feedback edge leaves down set, with `drive_o` = 2'b01, indefinitely. A later reference edge completes the overlap and returns the code to 2'b00.
- R8: `lock_o` rises after LOCK_COUNT consecutive error pulses, each at most OVERLAP_CYCLES+1 cycles wide. It does not rise after fewer such pulses.
- R9: An error pulse wider than OVERLAP_CYCLES+1 clears `lock_o` and restarts the count of narrow pulses.
- R10: While the synchronous active-high `rst` is high, both requests, `err_o` and `lock_o` read 0 and `drive_o` reads 2'b00.
- R11: `err_o` is high exactly when at least one request is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference signal (asynchronous) |
| fb_i | input | 1 | Feedback comparison signal (asynchronous) |
| up_o | output | 1 | Up request |
| dn_o | output | 1 | Down request |
| drive_o | output | 2 | Drive code: 10 source, 01 sink, 00 high-impedance, 11 overlap |
| err_o | output | 1 | Error pulse, high while either request is high |
| lock_o | output | 1 | Lock indicator |

## Verification
The hardest state to reach from the ports is the boundary of the lock qualifier. The bench must produce a run of pulses exactly one cycle wider than the overlap, which must still count as narrow, and then a pulse two cycles wider, which must drop the flag. It gets there by driving both inputs inside fixed windows and offsetting the feedback rise from the reference rise by a chosen number of cycles. Because both inputs see the same synchronizer latency, the offset sets the pulse width exactly. The bench also checks the error-pulse width of every window. Long free-running patterns with unequal periods cover the frequency-error cases.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        DRV_HIZ    = 2'b00,
        DRV_SINK   = 2'b01,
        DRV_SOURCE = 2'b10,
        DRV_BOTH   = 2'b11
    } drive_t;

    typedef struct packed {
        logic up;
        logic dn;
    } req_t;

    localparam int NUM_IN = 2;
    localparam int IDX_REF = 0;
    localparam int IDX_FB  = 1;

    function automatic drive_t req_to_drive(req_t r);
        return drive_t'({r.up, r.dn});
    endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= sig_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int OVERLAP_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_rise_i,
    input  logic fb_rise_i,
    output req_t req_o
);
    localparam int OW = (OVERLAP_CYCLES > 1) ? $clog2(OVERLAP_CYCLES) : 1;
    localparam logic [OW-1:0] OVL_LAST = OW'(OVERLAP_CYCLES - 1);

    req_t          req_q;
    logic [OW-1:0] ovl_q;
    logic          both;

    assign both = req_q.up & req_q.dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            ovl_q <= '0;
        end else if (both) begin
            if (ovl_q == OVL_LAST) begin
                req_q <= '0;
                ovl_q <= '0;
            end else begin
                ovl_q <= ovl_q + 1'b1;
            end
        end else begin
            req_q.up <= req_q.up | ref_rise_i;
            req_q.dn <= req_q.dn | fb_rise_i;
        end
    end

    assign req_o = req_q;

    // R3: the pair is held until the overlap counter finishes
    p_overlap_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (both && ovl_q != OVL_LAST) |=> (req_q.up && req_q.dn));
    // R3: neither request drops without the other
    p_joint_clear_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(req_q.up) |-> $fell(req_q.dn));
    p_joint_clear_dn_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(req_q.dn) |-> $fell(req_q.up));
    // R1: no request appears without an edge
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        (!req_q.up && !req_q.dn && !ref_rise_i && !fb_rise_i) |=> (!req_q.up && !req_q.dn));
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
    parameter int OVERLAP_CYCLES = 2,
    parameter int LOCK_COUNT     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic err_i,
    output logic lock_o
);
    localparam int LIMIT = OVERLAP_CYCLES + 1;
    localparam int WW    = $clog2(LIMIT + 2);
    localparam int CW    = $clog2(LOCK_COUNT + 1);
    localparam logic [WW-1:0] W_LIMIT = WW'(LIMIT);
    localparam logic [WW-1:0] W_SAT   = WW'(LIMIT + 1);
    localparam logic [CW-1:0] C_FULL  = CW'(LOCK_COUNT);
    localparam logic [CW-1:0] C_LAST  = CW'(LOCK_COUNT - 1);

    logic [WW-1:0] width_q;
    logic [CW-1:0] good_q;
    logic          lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= '0;
            good_q  <= '0;
            lock_q  <= 1'b0;
        end else if (err_i) begin
            if (width_q != W_SAT) width_q <= width_q + 1'b1;
            if (width_q == W_LIMIT) begin
                good_q <= '0;
                lock_q <= 1'b0;
            end
        end else if (width_q != '0) begin
            width_q <= '0;
            if (width_q <= W_LIMIT) begin
                if (good_q >= C_LAST) lock_q <= 1'b1;
                if (good_q != C_FULL) good_q <= good_q + 1'b1;
            end
        end
    end

    assign lock_o = lock_q;

    // R8: the flag only rises at the end of a pulse
    p_lock_at_pulse_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(!err_i));
    // R9: a pulse reaching LIMIT+1 cycles drops the flag
    p_wide_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
        (err_i && width_q == W_LIMIT) |=> !lock_q);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int OVERLAP_CYCLES = 2,
    parameter int LOCK_COUNT     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_i,
    input  logic       fb_i,
    output logic       up_o,
    output logic       dn_o,
    output logic [1:0] drive_o,
    output logic       err_o,
    output logic       lock_o
);
    logic [NUM_IN-1:0] raw;
    logic [NUM_IN-1:0] rise;
    req_t              req;
    drive_t            drv;

    assign raw[IDX_REF] = ref_i;
    assign raw[IDX_FB]  = fb_i;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_edge
        pfd_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .sig_i  (raw[g]),
            .rise_o (rise[g])
        );
    end

    pfd_core #(.OVERLAP_CYCLES(OVERLAP_CYCLES)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ref_rise_i (rise[IDX_REF]),
        .fb_rise_i  (rise[IDX_FB]),
        .req_o      (req)
    );

    assign drv     = req_to_drive(req);
    assign up_o    = req.up;
    assign dn_o    = req.dn;
    assign drive_o = drv;
    assign err_o   = req.up | req.dn;

    pfd_lock #(.OVERLAP_CYCLES(OVERLAP_CYCLES), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .err_i  (err_o),
        .lock_o (lock_o)
    );

    // R11: the error pulse matches the drive code being non-idle
    p_err_vs_code_r11: assert property (@(posedge clk) disable iff (rst)
        (drive_o == 2'b00) == !err_o);
endmodule

// File: tb/pfd_lock_top_tb_top.sv
module pfd_lock_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OVL        = 2;
    localparam int LCNT       = 4;
    localparam int WIN        = 24;
    localparam int HI         = 6;
    localparam int MAX_CYC    = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_i = 1'b0;
    logic       fb_i = 1'b0;
    logic       up_o, dn_o, err_o, lock_o;
    logic [1:0] drive_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_top #(.OVERLAP_CYCLES(OVL), .LOCK_COUNT(LCNT)) dut_i (
        .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i),
        .up_o(up_o), .dn_o(dn_o), .drive_o(drive_o), .err_o(err_o), .lock_o(lock_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > MAX_CYC && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, expected at most %0d", cyc, MAX_CYC);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_i = 1'b0; fb_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    int w_err, w_both, w_src, w_snk;

    // one window: ref rises at rd, fb at fd; widths counted per code
    task automatic run_window(int rd, int fd);
        w_err = 0; w_both = 0; w_src = 0; w_snk = 0;
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (err_o) w_err++;
            if (drive_o == 2'b11) w_both++;
            if (drive_o == 2'b10) w_src++;
            if (drive_o == 2'b01) w_snk++;
            ref_i = (c >= rd && c < rd + HI);
            fb_i  = (c >= fd && c < fd + HI);
        end
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (err_o) w_err++;
            if (drive_o == 2'b11) w_both++;
            if (drive_o == 2'b10) w_src++;
            if (drive_o == 2'b01) w_snk++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 up", up_o, 0);
        check("R10 dn", dn_o, 0);
        check("R10 drive", drive_o, 0);
        check("R10 lock", lock_o, 0);
    endtask

    task automatic t_aligned();
        run_window(2, 2);
        check("R4 aligned width", w_err, OVL);
        check("R3 overlap code", w_both, OVL);
        check("R3 idle after", drive_o, 0);
    endtask

    task automatic t_ref_leads(int d);
        run_window(1, 1 + d);
        check("R4 ref lead width", w_err, d + OVL);
        check("R1 source cycles", w_src, d);
        check("R3 overlap", w_both, OVL);
    endtask

    task automatic t_fb_leads(int d);
        run_window(1 + d, 1);
        check("R4 fb lead width", w_err, d + OVL);
        check("R2 sink cycles", w_snk, d);
        check("R2 no source", w_src, 0);
    endtask

    task automatic t_lock();
        do_reset();
        for (int k = 0; k < LCNT - 1; k++) run_window(2, 2);
        check("R8 not yet locked", lock_o, 0);
        run_window(2, 2);
        check("R8 locked", lock_o, 1);
        run_window(2, 4);
        check("R9 wide pulse width", w_err, OVL + 2);
        check("R9 unlocked", lock_o, 0);
        for (int k = 0; k < LCNT - 1; k++) run_window(2, 3);
        check("R9 count restarted", lock_o, 0);
        run_window(2, 3);
        check("R8 boundary width", w_err, OVL + 1);
        check("R8 lock at boundary", lock_o, 1);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        ref_i = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 up alone", drive_o, 2);
        rst = 1'b1;
        @(negedge clk);
        check("R10 up cleared", up_o, 0);
        check("R10 lock cleared", lock_o, 0);
        check("R10 err cleared", err_o, 0);
        ref_i = 1'b0;
        do_reset();
    endtask

    task automatic t_no_ref();
        do_reset();
        run_window(WIN + 10, 2);
        check("R7 sink held", drive_o, 1);
        run_window(WIN + 10, 2);
        check("R7 still sink", drive_o, 1);
        check("R7 no source", w_src, 0);
        run_window(2, WIN + 10);
        check("R7 overlap done", w_both, OVL);
        check("R7 idle", drive_o, 0);
    endtask

    task automatic t_freq(int rp, int fp, output int src, output int snk);
        do_reset();
        src = 0; snk = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (drive_o == 2'b10) src++;
            if (drive_o == 2'b01) snk++;
            ref_i = (c % rp) < rp / 2;
            fb_i  = (c % fp) < fp / 2;
        end
        @(negedge clk);
        ref_i = 1'b0; fb_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        int s, k;
        do_reset();
        rst = 1'b1;
        t_reset();
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 quiet inputs", err_o, 0);
        t_aligned();
        t_ref_leads(3);
        t_ref_leads(1);
        t_fb_leads(4);
        t_lock();
        t_reset_mid();
        t_no_ref();
        t_freq(8, 13, s, k);
        check("R5 source dominates", int'(s > k), 1);
        t_freq(13, 8, s, k);
        check("R6 sink dominates", int'(k > s), 1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule